// File: doc/BRIEF.md
# Raster Timing Generator with Deferred Base Reload

This block turns a single pixel clock into the raster control of a parallel RGB panel. It produces horizontal sync, vertical sync, data enable and the column and row of the pixel being scanned. It also produces the byte address of that pixel in a framebuffer of 4-byte pixels. The default geometry is a 480x272 panel. Each line has a 4-clock pulse, a 43-clock back porch, 480 visible clocks and an 8-clock front porch. Each frame has a 4-line pulse, a 12-line back porch, 272 visible lines and an 8-line front porch. At a pixel clock of roughly 9 to 9.5 MHz this gives a refresh rate close to 60 Hz.

The framebuffer base is held twice: a shadow copy that software may write at any time, and an active copy that the address arithmetic uses. A reload request arms a pending flag. The shadow value moves into the active copy only at the first clock of vertical blanking. That clock is the first clock of the first line after the last visible line. A one-clock completion pulse then marks the swap, so a renderer can flip between two buffers without tearing.

Two conventions exist for counting the back porch. A parameter selects between them, so one set of numbers fits either way a panel's timing table may be written.

Top module: `disp_timing_gen`

## Requirements
- R1: With the line counter at 0 on the first clock after reset, each line is a sync pulse of H_SYNC clocks, then the back porch, then H_ACT visible clocks, then H_FRONT clocks. hsync is asserted only during the pulse.
- R2: Each frame is a sync pulse of V_SYNC lines, then the back porch, then V_ACT visible lines, then V_FRONT lines. The frame starts with the pulse, and the line count advances only when a line wraps. vsync is asserted for whole lines of the pulse.
- R3: With PULSE_IN_BACK=0, the back porch follows the pulse, so a line lasts H_SYNC+H_BACK+H_ACT+H_FRONT clocks; the frame is formed the same way. With PULSE_IN_BACK=1, the pulse is counted inside the back porch, so a line lasts H_BACK+H_ACT+H_FRONT clocks and a frame lasts V_BACK+V_ACT+V_FRONT lines.
- R4: de_o is 1 only when the scan position is inside both the visible columns and the visible rows. Neither sync is asserted while de_o is 1.
- R5: While de_o is 1, x_o and y_o give the column (0..H_ACT-1) and row (0..V_ACT-1) of the visible area. Outside it, both read 0.
- R6: While de_o is 1, addr_o = active_base + (x_o + y_o*H_ACT)*4. Outside the visible area it reads 0.
- R7: With SYNC_LOW=1, both syncs are active low. With SYNC_LOW=0, both are active high.
- R8: A write through shadow_we with no commit changes neither addr_o nor the active base.
- R9: A pending reload is committed at the last clock of the last visible line. From the next clock, addr_o uses the shadow value that was held at that edge, and reload_done_o is 1 for exactly that one clock.
- R10: A reload request raised during blanking, including in the commit clock itself, is applied at the next frame's blanking and not the current one.
- R11: While no reload is pending, reload_done_o stays 0.
- R12: While rst is high and on the first clock after it, hsync_o and vsync_o are at their inactive level, and de_o, x_o, y_o, addr_o and reload_done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| shadow_we | input | 1 | Write strobe for the shadow base |
| shadow_base | input | AW | New framebuffer base for the shadow copy |
| reload_req | input | 1 | Arms a commit at the next vertical blanking |
| hsync_o | output | 1 | Horizontal sync, polarity per SYNC_LOW |
| vsync_o | output | 1 | Vertical sync, polarity per SYNC_LOW |
| de_o | output | 1 | Data enable for visible pixels |
| x_o | output | XW | Visible column, 0 when blank |
| y_o | output | YW | Visible row, 0 when blank |
| addr_o | output | AW | Byte address of the current pixel |
| reload_done_o | output | 1 | One-clock pulse when the base swap completes |

## Verification
The bench builds two copies with a shrunken raster: an 8x4 visible area with porches of one to three units, so a whole frame lasts about a hundred clocks. Many reloads, commit boundaries and frame wraps therefore fit in a short run. One copy uses PULSE_IN_BACK=0 with active-low syncs. The other uses PULSE_IN_BACK=1 with active-high syncs, which brings both porch conventions and both polarities within reach. Random shadow writes and requests land in visible area, in blanking and on the commit clock. Directed sequences add writes with no request and requests raised right after a completion.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    RG_SYNC  = 2'd0,
    RG_BACK  = 2'd1,
    RG_ACT   = 2'd2,
    RG_FRONT = 2'd3
  } region_e;

  // first visible count of an axis under either porch convention
  function automatic int vis_start(input int sync_w, input int back_w, input bit pulse_in_back);
    return pulse_in_back ? back_w : sync_w + back_w;
  endfunction

endpackage

// File: rtl/dtg_axis_counter.sv
module dtg_axis_counter
  import dtg_pkg::*;
#(
  parameter int SYNC_W = 4,
  parameter int BACK_W = 43,
  parameter int ACT_W = 480,
  parameter int FRONT_W = 8,
  parameter bit PULSE_IN_BACK = 1'b0,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output region_e       region,
  output logic          last
);

  localparam int START = vis_start(SYNC_W, BACK_W, PULSE_IN_BACK);
  localparam int TOTAL = START + ACT_W + FRONT_W;
  localparam logic [CW-1:0] SYNC_END = CW'(SYNC_W);
  localparam logic [CW-1:0] ACT_BEG = CW'(START);
  localparam logic [CW-1:0] ACT_END = CW'(START + ACT_W);
  localparam logic [CW-1:0] LAST_C = CW'(TOTAL - 1);

  assign last = (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    if (cnt < SYNC_END)      region = RG_SYNC;
    else if (cnt < ACT_BEG)  region = RG_BACK;
    else if (cnt < ACT_END)  region = RG_ACT;
    else                     region = RG_FRONT;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_C); // R1

endmodule

// File: rtl/dtg_base_shadow.sv
module dtg_base_shadow #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_base,
  input  logic          req,
  input  logic          commit_slot,
  output logic [AW-1:0] act_base,
  output logic          done
);

  logic [AW-1:0] shadow_q;
  logic          pending_q;
  logic          commit;

  assign commit = pending_q & commit_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      act_base  <= '0;
      pending_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (wr_en) shadow_q <= wr_base;
      if (commit) act_base <= shadow_q;
      pending_q <= (pending_q & ~commit) | req;
      done      <= commit;
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(act_base)); // R8

  AST_DONE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(pending_q)); // R11

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int H_SYNC = 4,
  parameter int H_BACK = 43,
  parameter int H_ACT = 480,
  parameter int H_FRONT = 8,
  parameter int V_SYNC = 4,
  parameter int V_BACK = 12,
  parameter int V_ACT = 272,
  parameter int V_FRONT = 8,
  parameter bit PULSE_IN_BACK = 1'b0,
  parameter bit SYNC_LOW = 1'b1,
  parameter int AW = 32,
  parameter int XW = $clog2(H_ACT),
  parameter int YW = $clog2(V_ACT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shadow_we,
  input  logic [AW-1:0] shadow_base,
  input  logic          reload_req,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [AW-1:0] addr_o,
  output logic          reload_done_o
);

  localparam int H_START = vis_start(H_SYNC, H_BACK, PULSE_IN_BACK);
  localparam int V_START = vis_start(V_SYNC, V_BACK, PULSE_IN_BACK);
  localparam int H_TOTAL = H_START + H_ACT + H_FRONT;
  localparam int V_TOTAL = V_START + V_ACT + V_FRONT;
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);
  localparam logic [HCW-1:0] H_START_C = HCW'(H_START);
  localparam logic [VCW-1:0] V_START_C = VCW'(V_START);
  localparam logic [VCW-1:0] V_LAST_VIS = VCW'(V_START + V_ACT - 1);
  localparam logic [VCW-1:0] V_BLANK_0 = VCW'(V_START + V_ACT);
  localparam logic SYNC_IDLE = SYNC_LOW;

  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  region_e        h_reg, v_reg;
  logic           h_last, v_last;
  logic [AW-1:0]  act_base;
  logic           commit_slot;
  logic           vis;
  logic [XW-1:0]  x_n;
  logic [YW-1:0]  y_n;
  logic [AW-1:0]  pix_idx;
  logic [AW-1:0]  addr_n;

  dtg_axis_counter #(
    .SYNC_W(H_SYNC), .BACK_W(H_BACK), .ACT_W(H_ACT), .FRONT_W(H_FRONT),
    .PULSE_IN_BACK(PULSE_IN_BACK), .CW(HCW)
  ) u_hcnt (
    .clk(clk), .rst(rst), .step(1'b1),
    .cnt(h_cnt), .region(h_reg), .last(h_last)
  );

  dtg_axis_counter #(
    .SYNC_W(V_SYNC), .BACK_W(V_BACK), .ACT_W(V_ACT), .FRONT_W(V_FRONT),
    .PULSE_IN_BACK(PULSE_IN_BACK), .CW(VCW)
  ) u_vcnt (
    .clk(clk), .rst(rst), .step(h_last),
    .cnt(v_cnt), .region(v_reg), .last(v_last)
  );

  // last clock of the last visible line: next edge enters vertical blanking
  assign commit_slot = h_last & (v_cnt == V_LAST_VIS);

  dtg_base_shadow #(.AW(AW)) u_base (
    .clk(clk), .rst(rst),
    .wr_en(shadow_we), .wr_base(shadow_base),
    .req(reload_req), .commit_slot(commit_slot),
    .act_base(act_base), .done(reload_done_o)
  );

  assign vis     = (h_reg == RG_ACT) && (v_reg == RG_ACT);
  assign x_n     = vis ? XW'(h_cnt - H_START_C) : '0;
  assign y_n     = vis ? YW'(v_cnt - V_START_C) : '0;
  assign pix_idx = AW'(x_n) + AW'(y_n) * AW'(H_ACT);
  assign addr_n  = vis ? act_base + (pix_idx << 2) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= SYNC_IDLE;
      vsync_o <= SYNC_IDLE;
      de_o    <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      addr_o  <= '0;
    end else begin
      hsync_o <= (h_reg == RG_SYNC) ^ SYNC_LOW;
      vsync_o <= (v_reg == RG_SYNC) ^ SYNC_LOW;
      de_o    <= vis;
      x_o     <= x_n;
      y_o     <= y_n;
      addr_o  <= addr_n;
    end
  end

  AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hsync_o == SYNC_IDLE) && (vsync_o == SYNC_IDLE)); // R4

  AST_COORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (x_o == '0) && (y_o == '0) && (addr_o == '0)); // R5

  AST_VSTEP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    !h_last |=> $stable(v_cnt)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reload_done_o |=> !reload_done_o); // R9

  AST_DONE_AT_BLANK: assert property (@(posedge clk) disable iff (rst)
    reload_done_o |-> (v_cnt == V_BLANK_0) && (h_cnt == '0)); // R10

  AST_NO_LAST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    v_last |-> v_reg == RG_FRONT); // R3

endmodule

// File: tb/test_disp_timing_gen.sv
module test_ref #(
  parameter int HS = 2, HB = 3, HA = 8, HF = 2,
  parameter int VS = 1, VB = 2, VA = 4, VF = 1,
  parameter bit PIB = 1'b0, LOWP = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        req,
  output logic        e_hs,
  output logic        e_vs,
  output logic        e_de,
  output int          e_x,
  output int          e_y,
  output logic [31:0] e_addr,
  output logic        e_done
);
  int h, v;
  logic [31:0] base, shadow;
  logic pend, fire;
  int hst, vst, htot, vtot;

  initial begin
    hst  = PIB ? HB : HS + HB;
    vst  = PIB ? VB : VS + VB;
    htot = hst + HA + HF;
    vtot = vst + VA + VF;
  end

  always @(posedge clk) begin
    if (rst) begin
      h = 0; v = 0; base = 0; shadow = 0; pend = 0;
      e_hs = LOWP; e_vs = LOWP; e_de = 0; e_x = 0; e_y = 0; e_addr = 0; e_done = 0;
    end else begin
      e_hs = (h < HS) ? !LOWP : LOWP;
      e_vs = (v < VS) ? !LOWP : LOWP;
      e_de = (h >= hst) && (h < hst + HA) && (v >= vst) && (v < vst + VA);
      e_x = e_de ? h - hst : 0;
      e_y = e_de ? v - vst : 0;
      e_addr = e_de ? base + 32'((e_x + e_y * HA) * 4) : 32'd0;
      fire = pend && (h == htot - 1) && (v == vst + VA - 1);
      e_done = fire;
      if (fire) base = shadow;
      pend = (pend && !fire) || req;
      if (we) shadow = wdata;
      if (h == htot - 1) begin
        h = 0;
        v = (v == vtot - 1) ? 0 : v + 1;
      end else begin
        h = h + 1;
      end
    end
  end
endmodule

module test_disp_timing_gen;
  localparam int HS = 2, HB = 3, HA = 8, HF = 2;
  localparam int VS = 1, VB = 2, VA = 4, VF = 1;
  localparam int XW = 3, YW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic req = 1'b0;

  logic a_hs, a_vs, a_de, a_done, b_hs, b_vs, b_de, b_done;
  logic [XW-1:0] a_x, b_x;
  logic [YW-1:0] a_y, b_y;
  logic [31:0] a_addr, b_addr;

  logic ea_hs, ea_vs, ea_de, ea_done, eb_hs, eb_vs, eb_de, eb_done;
  int ea_x, ea_y, eb_x, eb_y;
  logic [31:0] ea_addr, eb_addr;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  disp_timing_gen #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACT(HA), .H_FRONT(HF),
    .V_SYNC(VS), .V_BACK(VB), .V_ACT(VA), .V_FRONT(VF),
    .PULSE_IN_BACK(1'b0), .SYNC_LOW(1'b1), .AW(32), .XW(XW), .YW(YW)
  ) i_disp_timing_gen (
    .clk(clk), .rst(rst), .shadow_we(we), .shadow_base(wdata), .reload_req(req),
    .hsync_o(a_hs), .vsync_o(a_vs), .de_o(a_de), .x_o(a_x), .y_o(a_y),
    .addr_o(a_addr), .reload_done_o(a_done)
  );

  disp_timing_gen #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACT(HA), .H_FRONT(HF),
    .V_SYNC(VS), .V_BACK(VB), .V_ACT(VA), .V_FRONT(VF),
    .PULSE_IN_BACK(1'b1), .SYNC_LOW(1'b0), .AW(32), .XW(XW), .YW(YW)
  ) i_disp_timing_gen_b (
    .clk(clk), .rst(rst), .shadow_we(we), .shadow_base(wdata), .reload_req(req),
    .hsync_o(b_hs), .vsync_o(b_vs), .de_o(b_de), .x_o(b_x), .y_o(b_y),
    .addr_o(b_addr), .reload_done_o(b_done)
  );

  test_ref #(.HS(HS), .HB(HB), .HA(HA), .HF(HF), .VS(VS), .VB(VB), .VA(VA), .VF(VF),
             .PIB(1'b0), .LOWP(1'b1)) u_ref_a (
    .clk(clk), .rst(rst), .we(we), .wdata(wdata), .req(req),
    .e_hs(ea_hs), .e_vs(ea_vs), .e_de(ea_de), .e_x(ea_x), .e_y(ea_y),
    .e_addr(ea_addr), .e_done(ea_done)
  );

  test_ref #(.HS(HS), .HB(HB), .HA(HA), .HF(HF), .VS(VS), .VB(VB), .VA(VA), .VF(VF),
             .PIB(1'b1), .LOWP(1'b0)) u_ref_b (
    .clk(clk), .rst(rst), .we(we), .wdata(wdata), .req(req),
    .e_hs(eb_hs), .e_vs(eb_vs), .e_de(eb_de), .e_x(eb_x), .e_y(eb_y),
    .e_addr(eb_addr), .e_done(eb_done)
  );

  function automatic int line_len(input bit pib);
    return pib ? HB + HA + HF : HS + HB + HA + HF;
  endfunction

  function automatic int frame_len(input bit pib);
    return line_len(pib) * (pib ? VB + VA + VF : VS + VB + VA + VF);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // cycle-by-cycle comparison against the reference models
  always @(negedge clk) begin
    cyc++;
    check("R1 R7 hsync A", a_hs, ea_hs);
    check("R2 R7 vsync A", a_vs, ea_vs);
    check("R4 de A", a_de, ea_de);
    check("R5 x A", a_x, ea_x);
    check("R5 y A", a_y, ea_y);
    check("R6 R8 addr A", a_addr, ea_addr);
    check("R9 R10 R11 done A", a_done, ea_done);
    check("R1 R7 hsync B", b_hs, eb_hs);
    check("R2 R7 vsync B", b_vs, eb_vs);
    check("R4 de B", b_de, eb_de);
    check("R5 x B", b_x, eb_x);
    check("R5 y B", b_y, eb_y);
    check("R6 R8 addr B", b_addr, eb_addr);
    check("R9 R10 R11 done B", b_done, eb_done);
  end

  // sync period measurement for both porch conventions
  int a_hl = -1, a_vl = -1, b_hl = -1, b_vl = -1;
  logic a_hp = 0, a_vp = 0, b_hp = 0, b_vp = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!a_hs && a_hp) begin
        if (a_hl >= 0) check("R3 line period A", cyc - a_hl, line_len(1'b0));
        a_hl = cyc;
      end
      if (!a_vs && a_vp) begin
        if (a_vl >= 0) check("R3 frame period A", cyc - a_vl, frame_len(1'b0));
        a_vl = cyc;
      end
      if (b_hs && !b_hp) begin
        if (b_hl >= 0) check("R3 line period B", cyc - b_hl, line_len(1'b1));
        b_hl = cyc;
      end
      if (b_vs && !b_vp) begin
        if (b_vl >= 0) check("R3 frame period B", cyc - b_vl, frame_len(1'b1));
        b_vl = cyc;
      end
    end
    a_hp = a_hs; a_vp = a_vs; b_hp = b_hs; b_vp = b_vs;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    idle(3);
    // R12: reset values while reset is held
    check("R12 hsync A idle", a_hs, 1);
    check("R12 hsync B idle", b_hs, 0);
    check("R12 de A", a_de, 0);
    check("R12 addr A", a_addr, 0);
    check("R12 done B", b_done, 0);
    rst = 1'b0;
    // R8: shadow write without request, one full frame
    we = 1'b1; wdata = 32'h0001_0000;
    @(negedge clk); we = 1'b0;
    idle(frame_len(1'b0) + 5);
    // R9: request, then a second request right after completion (R10)
    req = 1'b1; @(negedge clk); req = 1'b0;
    while (!a_done) @(negedge clk);
    we = 1'b1; wdata = 32'h0002_0000; req = 1'b1;
    @(negedge clk); we = 1'b0; req = 1'b0;
    idle(2 * frame_len(1'b0) + 5);
    // randomised writes and requests
    for (int k = 0; k < 4000; k++) begin
      we = ($urandom % 19) == 0;
      wdata = {$urandom % 32'h0010_0000, 2'b00} & 32'hFFFF_FFFC;
      req = ($urandom % 61) == 0;
      @(negedge clk);
    end
    we = 1'b0; req = 1'b0;
    idle(20);
    finish_run();
  end

endmodule